// File: doc/BRIEF.md
# Switchable Pin Control Sequencer

This block drives the enable lines of the circuits that let a group of package pins either carry supply current or act as an extra memory bus. The pins of each borrowed bus can be in one of two roles. In single-bus mode they deliver power, and every DRAM device is reached over the shared bus. In multi-bus mode they carry signals, and each device is reached over its own bus. All borrowed buses change role together.

The block takes a requested mode and, for each cycle, the data transfer direction. On every change of role it first turns off all tri-state buffers and the power switch for a fixed break-before-make gap. It then turns on the enables of the new role and counts out the time needed for the supply rail and the clock/voltage operating point to settle. A ready flag stays low until that count expires.

Machine states: `PS_SINGLE` (power role, usable) and `PS_MULTI` (signal role, usable) are the steady states. `PS_GAP` has every enable off. `PS_SET_SGL` and `PS_SET_MUL` apply the new role's enables while the settle count runs. The transitions are:
- request-up moves `PS_SINGLE` to `PS_GAP`.
- request-down moves `PS_MULTI` to `PS_GAP`.
- gap-expired moves `PS_GAP` to `PS_SET_MUL` when multi is requested, and otherwise to `PS_SET_SGL`.
- settle-expired moves `PS_SET_SGL` to `PS_SINGLE`, or `PS_SET_MUL` to `PS_MULTI`.
- abort moves `PS_SET_SGL` to `PS_GAP` when multi is requested, or `PS_SET_MUL` to `PS_GAP` when single is requested.

Top module: `pinsw_seq`

## Requirements
- R1: After reset the block is in single-bus mode with `mode_ready` high. On every bus the power enable and the single-mode path enable are high, and every other enable is low.
- R2: In single-bus mode, including its settle period, each bus has `pwr_en` and `path_main_en` high, and `ca_en`, `dq_rd_en`, `dq_wr_en` and `path_alt_en` low.
- R3: In multi-bus mode, including its settle period, each bus has `pwr_en` and `path_main_en` low, and `ca_en` and `path_alt_en` high. Exactly one data enable is high: `dq_wr_en` when the held direction is 1 (write, controller to device), and `dq_rd_en` when it is 0 (read, device to controller).
- R4: When `mode_req` differs from the current role, every enable on every bus is low for exactly `GAP_CYC` cycles (default 2), starting the cycle after the request is sampled. Only after that gap is any enable of the other role raised.
- R5: `mode_ready` is low through the gap and through `CLK_MHZ*SETTLE_US` settle cycles (default 2000, that is 20 µs at 100 MHz). It goes high in the following cycle.
- R6: During the multi-bus settle period the data direction is frozen at the `dir_wr` value sampled on the edge that ends the gap. Once multi-bus mode is ready, the data enables follow `dir_wr` one cycle later.
- R7: If the request reverses during a settle period, the block abandons it and runs a new gap, followed by the settle period of the requested role.
- R8: `multi_active` is high exactly during the multi-bus settle period and in ready multi-bus mode.
- R9: In single-bus mode `dir_wr` has no effect on any output.
- R10: All `NUM_BUS` buses carry identical enable values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested mode, 1 = multi-bus |
| dir_wr | input | 1 | Data direction, 1 = write, 0 = read |
| pwr_en | output | NUM_BUS | Power switch enable per bus |
| ca_en | output | NUM_BUS | Command/address one-way buffer enable per bus |
| dq_rd_en | output | NUM_BUS | Data buffer enable, device to controller |
| dq_wr_en | output | NUM_BUS | Data buffer enable, controller to device |
| path_main_en | output | NUM_BUS | Device path via shared bus |
| path_alt_en | output | NUM_BUS | Device path via own borrowed bus |
| mode_ready | output | 1 | Current mode is usable |
| multi_active | output | 1 | Pins are in the signal role |

## Verification
The hardest situations to reach are the boundaries of a transition. One is a request that reverses in the middle of a settle period. Another is a direction change that lands exactly on the edge that ends the gap, or while the multi-bus settle count is running. The stimulus times its request reversals and direction toggles against a cycle count taken from the moment of the request, so these edges are hit on purpose. A behavioural reference model runs alongside the design and compares every output in every cycle, including during the 2000-cycle settle windows.

// File: rtl/pinsw_pkg.sv
package pinsw_pkg;

    typedef enum logic [2:0] {
        PS_SINGLE  = 3'd0,
        PS_GAP     = 3'd1,
        PS_SET_SGL = 3'd2,
        PS_SET_MUL = 3'd3,
        PS_MULTI   = 3'd4
    } pinsw_state_e;

    typedef struct packed {
        logic pwr;
        logic ca;
        logic dq_rd;
        logic dq_wr;
        logic path_main;
        logic path_alt;
    } pin_ctrl_t;

endpackage

// File: rtl/pinsw_timer.sv
module pinsw_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pinsw_fsm.sv
module pinsw_fsm
    import pinsw_pkg::*;
#(
    parameter int GAP_CYC    = 2,
    parameter int SETTLE_CYC = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_req,
    input  logic      dir_wr,
    output pin_ctrl_t ctrl,
    output logic      mode_ready,
    output logic      multi_active
);
    localparam int LONGEST = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] GAP_LAST    = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

    pinsw_state_e st_q, st_nx;
    logic [CW-1:0] cnt;
    logic          dir_q;
    logic          gap_done, settle_done;

    pinsw_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_nx != st_q),
        .cnt   (cnt)
    );

    assign gap_done    = (cnt == GAP_LAST);
    assign settle_done = (cnt == SETTLE_LAST);

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PS_SINGLE:  if (mode_req) st_nx = PS_GAP;
            PS_MULTI:   if (!mode_req) st_nx = PS_GAP;
            PS_GAP:     if (gap_done) st_nx = mode_req ? PS_SET_MUL : PS_SET_SGL;
            PS_SET_SGL: begin
                if (mode_req)         st_nx = PS_GAP;
                else if (settle_done) st_nx = PS_SINGLE;
            end
            PS_SET_MUL: begin
                if (!mode_req)        st_nx = PS_GAP;
                else if (settle_done) st_nx = PS_MULTI;
            end
            default:    st_nx = PS_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_SINGLE;
            dir_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            if ((st_q == PS_GAP && st_nx == PS_SET_MUL) || st_q == PS_MULTI) begin
                dir_q <= dir_wr;
            end
        end
    end

    always_comb begin
        ctrl         = '0;
        mode_ready   = 1'b0;
        multi_active = 1'b0;
        unique case (st_q)
            PS_SINGLE, PS_SET_SGL: begin
                ctrl.pwr       = 1'b1;
                ctrl.path_main = 1'b1;
                mode_ready     = (st_q == PS_SINGLE);
            end
            PS_SET_MUL, PS_MULTI: begin
                ctrl.ca       = 1'b1;
                ctrl.path_alt = 1'b1;
                ctrl.dq_wr    = dir_q;
                ctrl.dq_rd    = !dir_q;
                mode_ready    = (st_q == PS_MULTI);
                multi_active  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    // R6
    settle_dir_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SET_MUL && $past(st_q) == PS_SET_MUL) |-> $stable(dir_q));

    // R5
    ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_ready) |-> $past(cnt) == SETTLE_LAST);
endmodule

// File: rtl/pinsw_bus_drv.sv
module pinsw_bus_drv
    import pinsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_ctrl_t ctrl,
    output logic      pwr_en,
    output logic      ca_en,
    output logic      dq_rd_en,
    output logic      dq_wr_en,
    output logic      path_main_en,
    output logic      path_alt_en
);
    logic sig_any;

    assign pwr_en       = ctrl.pwr;
    assign ca_en        = ctrl.ca;
    assign dq_rd_en     = ctrl.dq_rd;
    assign dq_wr_en     = ctrl.dq_wr;
    assign path_main_en = ctrl.path_main;
    assign path_alt_en  = ctrl.path_alt;
    assign sig_any      = ctrl.ca | ctrl.dq_rd | ctrl.dq_wr | ctrl.path_alt;

    // R2
    pwr_sig_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en |-> !sig_any);

    // R3
    dq_dir_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dq_rd_en, dq_wr_en}));

    // R4
    pwr_bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> (!$past(sig_any) && !$past(sig_any, 2)));

    // R4
    sig_bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_any) |-> (!$past(pwr_en) && !$past(pwr_en, 2)
                            && !$past(path_main_en)));
endmodule

// File: rtl/pinsw_seq.sv
module pinsw_seq
    import pinsw_pkg::*;
#(
    parameter int NUM_BUS   = 3,
    parameter int GAP_CYC   = 2,
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_req,
    input  logic               dir_wr,
    output logic [NUM_BUS-1:0] pwr_en,
    output logic [NUM_BUS-1:0] ca_en,
    output logic [NUM_BUS-1:0] dq_rd_en,
    output logic [NUM_BUS-1:0] dq_wr_en,
    output logic [NUM_BUS-1:0] path_main_en,
    output logic [NUM_BUS-1:0] path_alt_en,
    output logic               mode_ready,
    output logic               multi_active
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    pin_ctrl_t ctrl;

    pinsw_fsm #(
        .GAP_CYC    (GAP_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_req     (mode_req),
        .dir_wr       (dir_wr),
        .ctrl         (ctrl),
        .mode_ready   (mode_ready),
        .multi_active (multi_active)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        pinsw_bus_drv drv_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctrl         (ctrl),
            .pwr_en       (pwr_en[b]),
            .ca_en        (ca_en[b]),
            .dq_rd_en     (dq_rd_en[b]),
            .dq_wr_en     (dq_wr_en[b]),
            .path_main_en (path_main_en[b]),
            .path_alt_en  (path_alt_en[b])
        );
    end

    // R10
    bus_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en == {NUM_BUS{pwr_en[0]}}) && (dq_wr_en == {NUM_BUS{dq_wr_en[0]}}));
endmodule

// File: tb/pinsw_seq_tb_top.sv
module pinsw_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 3;
    localparam int GAP        = 2;
    localparam int SETTLE     = 100 * 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_req = 1'b0;
    logic dir_wr = 1'b0;
    logic [NB-1:0] pwr_en, ca_en, dq_rd_en, dq_wr_en, path_main_en, path_alt_en;
    logic mode_ready, multi_active;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model: side 0 = power role, 1 = signal role;
    // phase 0 = steady, 1 = gap, 2 = settle
    int m_side = 0, m_phase = 0, m_left = 0;
    bit m_dir = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinsw_seq #(.NUM_BUS(NB), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .dir_wr(dir_wr),
        .pwr_en(pwr_en), .ca_en(ca_en), .dq_rd_en(dq_rd_en), .dq_wr_en(dq_wr_en),
        .path_main_en(path_main_en), .path_alt_en(path_alt_en),
        .mode_ready(mode_ready), .multi_active(multi_active)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_side = 0; m_phase = 0; m_left = 0; m_dir = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (int'(mode_req) != m_side) begin
                        m_phase = 1; m_left = GAP;
                    end else if (m_side == 1) begin
                        m_dir = dir_wr;
                    end
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_side = int'(mode_req); m_phase = 2; m_left = SETTLE;
                        if (mode_req) m_dir = dir_wr;
                    end
                end
                default: begin
                    if (int'(mode_req) != m_side) begin
                        m_phase = 1; m_left = GAP;
                    end else begin
                        m_left--;
                        if (m_left == 0) m_phase = 0;
                    end
                end
            endcase
        end
    end

    task automatic chk(string req, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    // compare every output each cycle against the model (R10: whole vectors)
    always @(negedge clk) begin
        logic [NB-1:0] all1, e_pwr, e_ca, e_rd, e_wr, e_main, e_alt;
        string tag;
        all1 = '1;
        e_pwr = '0; e_ca = '0; e_rd = '0; e_wr = '0; e_main = '0; e_alt = '0;
        if (m_phase != 1) begin
            if (m_side == 0) begin
                e_pwr = all1; e_main = all1;
            end else begin
                e_ca = all1; e_alt = all1;
                e_wr = m_dir ? all1 : '0;
                e_rd = m_dir ? '0 : all1;
            end
        end
        tag = (m_phase == 1) ? "R4" : ((m_side == 0) ? "R2" : "R3");
        chk(tag, "pwr_en", pwr_en, e_pwr);
        chk(tag, "ca_en", ca_en, e_ca);
        chk(tag, "dq_rd_en", dq_rd_en, e_rd);
        chk(tag, "dq_wr_en", dq_wr_en, e_wr);
        chk(tag, "path_main_en", path_main_en, e_main);
        chk(tag, "path_alt_en", path_alt_en, e_alt);
        chk("R5", "mode_ready", NB'(mode_ready), NB'(m_phase == 0));
        chk("R8", "multi_active", NB'(multi_active), NB'(m_side == 1 && m_phase != 1));
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        int guard = 0;
        @(negedge clk);
        while (!mode_ready && guard < 3 * SETTLE) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int lowcnt;
        wait_cyc(5);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1", "pwr_en after reset", pwr_en, '1);
        chk("R1", "ready after reset", NB'(mode_ready), NB'(1));

        // R9 direction toggles in single mode
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) dir_wr = ~dir_wr;
        end
        wait_cyc(1);
        chk("R9", "dq_wr_en in single", dq_wr_en, '0);
        chk("R9", "dq_rd_en in single", dq_rd_en, '0);

        // R5 ready-low window for single -> multi
        dir_wr = 1'b0;
        mode_req = 1'b1;
        lowcnt = 0;
        @(negedge clk);
        while (!mode_ready && lowcnt < 3 * SETTLE) begin
            lowcnt++;
            @(negedge clk);
        end
        chk("R5", "ready low cycles", NB'(lowcnt == GAP + SETTLE), NB'(1));

        // R6 direction follows in ready multi mode
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) dir_wr = (i % 3 == 0);
        end
        wait_cyc(1);
        chk("R6", "dq_wr_en follows", dq_wr_en, dir_wr ? '1 : '0);

        // back to single, toggling direction through the gap
        mode_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) dir_wr = ~dir_wr;
        end
        wait_ready();

        // R6 direction sampled at gap end, then frozen through settle
        mode_req = 1'b1;
        dir_wr = 1'b0;
        wait_cyc(1);
        dir_wr = 1'b1;
        wait_cyc(1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) dir_wr = ~dir_wr;
        end
        chk("R6", "dq_wr_en frozen during settle", dq_wr_en, '1);
        wait_ready();

        // R7 abort a single-side settle midway
        mode_req = 1'b0;
        wait_cyc(GAP + 300);
        mode_req = 1'b1;
        wait_cyc(1);
        chk("R7", "pwr_en dropped on abort", pwr_en, '0);
        wait_ready();
        chk("R7", "multi_active after abort", NB'(multi_active), NB'(1));

        // R7 abort a multi-side settle midway, then a one-cycle request pulse
        mode_req = 1'b0;
        wait_ready();
        mode_req = 1'b1;
        wait_cyc(GAP + 500);
        mode_req = 1'b0;
        wait_ready();
        chk("R7", "pwr_en after multi abort", pwr_en, '1);
        mode_req = 1'b1;
        wait_cyc(1);
        mode_req = 1'b0;
        wait_ready();
        chk("R4", "single after pulse", path_main_en, '1);
        wait_cyc(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule